// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Dispatcher

This block decides which of five interrupt sources the CPU services next. Peripherals raise requests by pulsing set inputs, which latch into a request-flag register. Software controls the sources through a per-source enable register, and the CPU controls a global master enable through set and clear inputs. A source is eligible when its request flag and its enable bit are both set. When the master enable is set and at least one source is eligible, the block picks the eligible source with the highest priority. On the next clock edge it pulses a dispatch strobe and presents that source's vector address.

The same edge clears the serviced source's request flag and the master enable. The enable register is left unchanged, so the source can be taken again once software sets the master enable back. A separate pending output shows whether any source is eligible, whatever the master enable says. The CPU can use it to leave a low-power wait.

Top module: `irq_dispatch`

## Requirements
- R1: After reset both registers read zero, the master enable is clear, and `dispatch_valid_o`, `pending_o` and `ime_o` are low.
- R2: `reg_addr_i`=0 selects the request-flag register and `reg_addr_i`=1 selects the enable register. Bit 0 is vertical blank, bit 1 display status, bit 2 timer, bit 3 serial and bit 4 joypad. `reg_rdata_o` shows the selected register combinationally, with bits 7:5 read as zero. A write takes effect at the next clock edge.
- R3: A `src_set_i` bit sets its flag at the next edge. It takes precedence over a register write and over a dispatch clear of the same bit in that cycle.
- R4: `pending_o` is high whenever (flags AND enables) is nonzero, regardless of the master enable.
- R5: No dispatch occurs while the master enable is clear.
- R6: Among eligible sources the lowest bit index wins. The vector is 0x40 + 8 × index: 0x40, 0x48, 0x50, 0x58 or 0x60.
- R7: A dispatch clears only the serviced source's request flag. The enable register is not modified.
- R8: A dispatch clears the master enable. `ime_clr_i` and a dispatch both take precedence over `ime_set_i` in the same cycle.
- R9: `dispatch_valid_o` is a one-cycle pulse, registered at the edge after the master enable and an eligible source are both seen. `dispatch_vec_o` is valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 1 | Register select: 0 request flags, 1 enables |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| src_set_i | input | 5 | Per-source request set pulses |
| ime_set_i | input | 1 | Set master enable |
| ime_clr_i | input | 1 | Clear master enable |
| dispatch_valid_o | output | 1 | One-cycle dispatch strobe |
| dispatch_vec_o | output | 8 | Vector of the dispatched source |
| pending_o | output | 1 | Some source is requested and enabled |
| ime_o | output | 1 | Master enable state |

## Verification
The hardest case to reach is a peripheral set pulse for a source landing in the same cycle as that source's dispatch. The dispatch must still happen, but the flag must stay set.

The bench reaches it by arming a single eligible source with the master enable clear. It then drives `ime_set_i` and, one cycle later, drives the set pulse exactly in the cycle the dispatch decision is registered. A stimulus table covers the priority and masking patterns.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NUM_SRC    = 5;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned VEC_W      = 8;
  localparam int unsigned VEC_BASE   = 'h40;
  localparam int unsigned VEC_STRIDE = 8;
endpackage

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  // per-bit priority: set > dispatch clear > write
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q[g] <= 1'b0;
      else if (set_i[g])  flag_q[g] <= 1'b1;
      else if (clr_i[g])  flag_q[g] <= 1'b0;
      else if (we_i)      flag_q[g] <= wdata_i[g];
    end

    // R7
    flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[g] && !set_i[g] |=> !flag_q[g]);
    // R3
    flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flag_q[g]);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_en_reg.sv
module irq_en_reg #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] en_o
);
  logic [N-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (we_i) en_q <= wdata_i;
  end

  assign en_o = en_q;

  // R7
  en_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(en_q));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N     = 5,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [N-1:0]     grant_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest index wins: scan downwards, last hit overrides
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        idx_o      = IDX_W'(i);
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/irq_master_en.sv
module irq_master_en (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic take_i,
  output logic ime_o
);
  logic ime_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ime_q <= 1'b0;
    else if (clr_i || take_i) ime_q <= 1'b0;
    else if (set_i)           ime_q <= 1'b1;
  end

  assign ime_o = ime_q;

  // R8
  ime_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> !ime_q);
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC  = NUM_SRC,
  parameter int unsigned D_W    = DATA_W,
  parameter int unsigned V_W    = VEC_W,
  parameter int unsigned V_BASE = VEC_BASE,
  parameter int unsigned V_STEP = VEC_STRIDE
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_addr_i,
  input  logic           reg_we_i,
  input  logic [D_W-1:0] reg_wdata_i,
  output logic [D_W-1:0] reg_rdata_o,
  input  logic [N_SRC-1:0] src_set_i,
  input  logic           ime_set_i,
  input  logic           ime_clr_i,
  output logic           dispatch_valid_o,
  output logic [V_W-1:0] dispatch_vec_o,
  output logic           pending_o,
  output logic           ime_o
);
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0] flag, en, elig, grant, clr;
  logic [IDX_W-1:0] idx;
  logic             any, ime, take;
  logic             valid_q;
  logic [V_W-1:0]   vec_q, vec_d;

  irq_flag_reg #(.N(N_SRC)) u_flag (
    .clk_i, .rst_ni,
    .we_i    (reg_we_i && !reg_addr_i),
    .wdata_i (reg_wdata_i[N_SRC-1:0]),
    .set_i   (src_set_i),
    .clr_i   (clr),
    .flag_o  (flag)
  );

  irq_en_reg #(.N(N_SRC)) u_en (
    .clk_i, .rst_ni,
    .we_i    (reg_we_i && reg_addr_i),
    .wdata_i (reg_wdata_i[N_SRC-1:0]),
    .en_o    (en)
  );

  assign elig = flag & en;

  irq_prio_pick #(.N(N_SRC)) u_pick (
    .req_i   (elig),
    .any_o   (any),
    .grant_o (grant),
    .idx_o   (idx)
  );

  assign take = ime && any;
  assign clr  = take ? grant : '0;

  irq_master_en u_ime (
    .clk_i, .rst_ni,
    .set_i  (ime_set_i),
    .clr_i  (ime_clr_i),
    .take_i (take),
    .ime_o  (ime)
  );

  assign vec_d = V_W'(V_BASE) + V_W'(idx) * V_W'(V_STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
    end else begin
      valid_q <= take;
      if (take) vec_q <= vec_d;
    end
  end

  assign reg_rdata_o      = reg_addr_i ? D_W'(en) : D_W'(flag);
  assign dispatch_valid_o = valid_q;
  assign dispatch_vec_o   = vec_q;
  assign pending_o        = any;
  assign ime_o            = ime;

  // R5
  no_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ime |=> !valid_q);
  // R9
  pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  // R8
  ime_after_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> !ime);
  // R6
  grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant) && ((grant & ~elig) == '0) && (any == (grant != '0)));
endmodule

// File: tb/sim_irq_dispatch.sv
module sim_irq_dispatch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr = 1'b0, we = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic [4:0] sset = '0;
  logic       iset = 1'b0, iclr = 1'b0;
  logic       dv, pend, ime;
  logic [7:0] vec;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_dispatch u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .src_set_i(sset), .ime_set_i(iset), .ime_clr_i(iclr),
    .dispatch_valid_o(dv), .dispatch_vec_o(vec),
    .pending_o(pend), .ime_o(ime)
  );

  // {flags, enables, expect dispatch, expect vector, flags after}
  localparam int NV = 8;
  localparam logic [23:0] TBL [NV] = '{
    {5'h1F, 5'h1F, 1'b1, 8'h40, 5'h1E},
    {5'h1E, 5'h1F, 1'b1, 8'h48, 5'h1C},
    {5'h14, 5'h1F, 1'b1, 8'h50, 5'h10},
    {5'h18, 5'h08, 1'b1, 8'h58, 5'h10},
    {5'h10, 5'h10, 1'b1, 8'h60, 5'h00},
    {5'h1F, 5'h00, 1'b0, 8'h00, 5'h1F},
    {5'h0A, 5'h05, 1'b0, 8'h00, 5'h0A},
    {5'h06, 5'h14, 1'b1, 8'h50, 5'h02}
  };

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic a, logic [7:0] d);
    addr = a; we = 1'b1; wdata = d;
    tick();
    we = 1'b0; addr = 1'b0;
  endtask

  task automatic ime_pulse_clr;
    iclr = 1'b1; tick(); iclr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    addr = 1'b0; #1 chk("R1 flags", rdata, 8'h00);
    addr = 1'b1; #1 chk("R1 enables", rdata, 8'h00);
    addr = 1'b0;
    chk("R1 valid", {7'b0, dv}, 8'h00);
    chk("R1 pending", {7'b0, pend}, 8'h00);
    chk("R1 ime", {7'b0, ime}, 8'h00);

    // R2 upper bits read zero
    wr(1'b1, 8'hFF);
    addr = 1'b1; #1 chk("R2 enable readback", rdata, 8'h1F);
    addr = 1'b0;

    // table walk: R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      logic [4:0] f, e, fa;
      logic       xv;
      logic [7:0] xvec;
      {f, e, xv, xvec, fa} = TBL[i];
      ime_pulse_clr();
      wr(1'b0, {3'b0, f});
      wr(1'b1, {3'b0, e});
      chk("R4 pending before", {7'b0, pend}, {7'b0, (f & e) != 0});
      iset = 1'b1; tick(); iset = 1'b0;
      tick();
      chk("R9 valid", {7'b0, dv}, {7'b0, xv});
      if (xv) chk("R6 vector", vec, xvec);
      chk("R7 flags after", rdata, {3'b0, fa});
      addr = 1'b1; #1 chk("R7 enables kept", rdata, {3'b0, e});
      addr = 1'b0;
      chk("R8 ime", {7'b0, ime}, {7'b0, ~xv});
      tick();
      chk("R9 one-cycle", {7'b0, dv}, 8'h00);
    end

    // R3 set pulse beats register write
    ime_pulse_clr();
    addr = 1'b0; we = 1'b1; wdata = 8'h00; sset = 5'h02;
    tick();
    we = 1'b0; sset = '0;
    chk("R3 set over write", rdata, 8'h02);

    // R3 set pulse beats dispatch clear
    wr(1'b0, 8'h01);
    wr(1'b1, 8'h01);
    iset = 1'b1; tick(); iset = 1'b0;
    sset = 5'h01; tick(); sset = '0;
    chk("R3 dispatch still taken", {7'b0, dv}, 8'h01);
    chk("R6 vblank vector", vec, 8'h40);
    chk("R3 flag kept", rdata, 8'h01);

    // R4 R5 pending with master enable clear, no dispatch
    chk("R4 pending ime clear", {7'b0, pend}, 8'h01);
    begin
      logic seen;
      seen = 1'b0;
      for (int k = 0; k < 4; k++) begin
        tick();
        if (dv) seen = 1'b1;
      end
      chk("R5 no dispatch", {7'b0, seen}, 8'h00);
    end

    // R8 clear wins over set
    iset = 1'b1; iclr = 1'b1; tick(); iset = 1'b0; iclr = 1'b0;
    chk("R8 clear over set", {7'b0, ime}, 8'h00);
    chk("R8 no dispatch", {7'b0, dv}, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule